// File: doc/BRIEF.md
# Open-Row Cache-Line Fetch Sequencer

This block sits between a cache that wants whole lines and one bank of a simplified DRAM. Each request names a row, a column and the index of the word the processor is waiting for. The block works out whether the row is already held in the bank's sense latches. A request to a different row closes the old row, opens the new one, then reads the column. A request to the open row goes straight to the column read. When no row has been opened since reset, the block opens the row without closing anything first. Between commands it waits the programmed close, open and read latencies. Each latency is held to its legal window.

The line comes back at two 64-bit words per clock, so a 64-byte line takes four clocks. The word the requester asked for is sent first. The rest of the line follows in ascending order and wraps past the end of the line. A strobe on the first data clock lets the requester resume before the line is complete. The sequencer takes a new request only when it is idle.

Top module: `lfs_line_sequencer`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` is 0, `rsp_valid` is 0, and no row is marked open.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the data burst has ended. A request presented while `req_ready` is 0 issues no command and leaves the open row unchanged.
- R3: For a request to a row other than the open one, the command pulses are as follows. Close (`cmd_kind`=1, carrying the old row) comes in the clock after acceptance. Open (`cmd_kind`=2, carrying the new row) comes tRP clocks later. Read (`cmd_kind`=3) comes tRCD clocks after that. The first data clock comes tCL clocks after the read.
- R4: With no row open, the open command comes in the clock after acceptance. The read follows tRCD clocks later, and data starts tCL clocks after the read. No close command is issued.
- R5: For a request to the open row, the read command comes in the clock after acceptance and data starts tCL clocks later. No close or open command is issued.
- R6: The effective tRP and tRCD are the programmed values held to the range 12 to 15. The effective tCL is held to the range 10 to 12. A value below a range acts as its minimum and a value above it acts as its maximum.
- R7: A burst lasts (line bytes / 16) consecutive clocks with `rsp_valid` high. Each clock carries two 64-bit words.
- R8: Let c be `req_crit` modulo the words per line. On burst clock k, lane 0 (`rd_sel[IDX-1:0]`, `rsp_data[63:0]`) carries word (c+2k) mod W, and lane 1 carries word (c+2k+1) mod W.
- R9: `rsp_first` is 1 only on the first burst clock and `rsp_last` only on the last one. While `rsp_valid` is 1, `rsp_data` is the memory words addressed by `rd_sel`.
- R10: The read command's `cmd_col` is the request column with its low log2(W) bits cleared. Close and open commands carry column 0.
- R11: Each command is a one-clock `cmd_valid` pulse, and no command is issued while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset |
| cfg_trp | input | DLY_W (5) | Programmed row-close latency |
| cfg_trcd | input | DLY_W (5) | Programmed row-open latency |
| cfg_tcl | input | DLY_W (5) | Programmed column-read latency |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_row | input | ROW_W (14) | Requested row |
| req_col | input | COL_W (10) | Requested column |
| req_crit | input | CRIT_W (4) | Index of the word needed first |
| cmd_valid | output | 1 | Command pulse to the bank |
| cmd_kind | output | 2 | 1 close, 2 open, 3 read |
| cmd_row | output | ROW_W (14) | Row for the command |
| cmd_col | output | COL_W (10) | Line-aligned column for read |
| rd_sel | output | 2*IDX (6) | Word index per lane fetched from the row latch |
| rd_data | input | 128 | Words returned by the bank for `rd_sel` |
| rsp_valid | output | 1 | Burst data valid |
| rsp_first | output | 1 | First burst clock, critical word present |
| rsp_last | output | 1 | Last burst clock |
| rsp_data | output | 128 | Two words of the line, lane 0 in the low half |

## Verification
The assertions check the rules that hold on every clock. Commands are single pulses and never overlap data. A burst opens with the first strobe and ends after the last strobe. Lane 0 advances by two words per burst clock. A hit goes straight to a read, a cold start goes straight to an open, and the timer stays inside the clamped window. Only the bench scenarios can show the exact gaps between commands for hits, misses and cold starts, the clamping of out-of-range delays, and the wrapped word order for each critical index. They also show that data matches the addressed row and column, and that a request made while busy leaves no trace.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CLOSE = 3'd1,
        PH_OPEN  = 3'd2,
        PH_READ  = 3'd3,
        PH_BURST = 3'd4
    } phase_e;

    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_CLOSE = 2'd1;
    localparam logic [1:0] CMD_OPEN  = 2'd2;
    localparam logic [1:0] CMD_READ  = 2'd3;

endpackage

// File: rtl/lfs_delay_clamp.sv
module lfs_delay_clamp #(
    parameter int DLY_W = 5,
    parameter int LO    = 12,
    parameter int HI    = 15
) (
    input  logic [DLY_W-1:0] raw,
    output logic [DLY_W-1:0] eff
);
    localparam logic [DLY_W-1:0] LO_V = DLY_W'(LO);
    localparam logic [DLY_W-1:0] HI_V = DLY_W'(HI);

    always_comb begin
        if (raw < LO_V) begin
            eff = LO_V;
        end else if (raw > HI_V) begin
            eff = HI_V;
        end else begin
            eff = raw;
        end
    end
endmodule

// File: rtl/lfs_phase_timer.sv
module lfs_phase_timer #(
    parameter int CNT_W   = 5,
    parameter int MAX_VAL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Loading value-1 makes the phase last exactly load_val clocks.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6: the clamped delays keep the count inside the legal window
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_VAL));

    p_load_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/lfs_wrap_order.sv
module lfs_wrap_order #(
    parameter int WORDS  = 8,
    parameter int LANES  = 2,
    parameter int IDX_W  = 3,
    parameter int BEAT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic                   last,
    input  logic [IDX_W-1:0]       crit,
    input  logic [BEAT_W-1:0]      beat,
    output logic [LANES*IDX_W-1:0] sel
);
    localparam int STEP_W = IDX_W + BEAT_W + 2;

    logic [STEP_W-1:0] base_off;
    assign base_off = STEP_W'(beat) * STEP_W'(LANES);

    // Power-of-two line: truncation to IDX_W performs the wrap.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STEP_W-1:0] sum;
        assign sum = STEP_W'(crit) + base_off + STEP_W'(l);
        assign sel[l*IDX_W +: IDX_W] = sum[IDX_W-1:0];
        logic unused_sum_hi;
        assign unused_sum_hi = ^sum[STEP_W-1:IDX_W];
    end

    // R8: lane 0 moves forward by LANES words per burst clock
    p_lane_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=>
            (sel[IDX_W-1:0] == IDX_W'($past(sel[IDX_W-1:0]) + IDX_W'(LANES))));

    localparam int UNUSED_W = WORDS;
    logic unused_words;
    assign unused_words = (UNUSED_W == 0);
endmodule

// File: rtl/lfs_line_sequencer.sv
module lfs_line_sequencer
    import lfs_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int WORD_BITS  = 64,
    parameter int ROW_W      = 14,
    parameter int COL_W      = 10,
    parameter int CRIT_W     = 4,
    parameter int DLY_W      = 5,
    parameter int TRP_LO     = 12,
    parameter int TRP_HI     = 15,
    parameter int TRCD_LO    = 12,
    parameter int TRCD_HI    = 15,
    parameter int TCL_LO     = 10,
    parameter int TCL_HI     = 12,
    parameter int LANES      = 2,
    localparam int WORDS     = LINE_BYTES / (WORD_BITS / 8),
    localparam int IDX_W     = $clog2(WORDS),
    localparam int BURST_CYC = WORDS / LANES,
    localparam int BEAT_W    = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1,
    localparam int DATA_W    = LANES * WORD_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DLY_W-1:0]       cfg_trp,
    input  logic [DLY_W-1:0]       cfg_trcd,
    input  logic [DLY_W-1:0]       cfg_tcl,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ROW_W-1:0]       req_row,
    input  logic [COL_W-1:0]       req_col,
    input  logic [CRIT_W-1:0]      req_crit,
    output logic                   cmd_valid,
    output logic [1:0]             cmd_kind,
    output logic [ROW_W-1:0]       cmd_row,
    output logic [COL_W-1:0]       cmd_col,
    output logic [LANES*IDX_W-1:0] rd_sel,
    input  logic [DATA_W-1:0]      rd_data,
    output logic                   rsp_valid,
    output logic                   rsp_first,
    output logic                   rsp_last,
    output logic [DATA_W-1:0]      rsp_data
);
    localparam int TMR_MAX_A = (TRP_HI > TRCD_HI) ? TRP_HI : TRCD_HI;
    localparam int TMR_MAX   = (TMR_MAX_A > TCL_HI) ? TMR_MAX_A : TCL_HI;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_CYC - 1);

    typedef struct packed {
        phase_e             phase;
        logic               open_vld;
        logic [ROW_W-1:0]   open_row;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col_base;
        logic [IDX_W-1:0]   crit;
        logic [BEAT_W-1:0]  beat;
        logic               cmd_valid;
        logic [1:0]         cmd_kind;
        logic [ROW_W-1:0]   cmd_row;
        logic [COL_W-1:0]   cmd_col;
        logic               rsp_valid;
        logic               rsp_first;
        logic               rsp_last;
    } seq_state_t;

    seq_state_t q, d;

    // ---------------- delay windows ----------------
    logic [DLY_W-1:0] trp_eff, trcd_eff, tcl_eff;

    lfs_delay_clamp #(.DLY_W(DLY_W), .LO(TRP_LO), .HI(TRP_HI)) i_clamp_trp (
        .raw(cfg_trp), .eff(trp_eff));
    lfs_delay_clamp #(.DLY_W(DLY_W), .LO(TRCD_LO), .HI(TRCD_HI)) i_clamp_trcd (
        .raw(cfg_trcd), .eff(trcd_eff));
    lfs_delay_clamp #(.DLY_W(DLY_W), .LO(TCL_LO), .HI(TCL_HI)) i_clamp_tcl (
        .raw(cfg_tcl), .eff(tcl_eff));

    // ---------------- phase timer ----------------
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_expired;

    lfs_phase_timer #(.CNT_W(DLY_W), .MAX_VAL(TMR_MAX)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    // ---------------- next-state logic ----------------
    logic accept;
    logic row_hit;

    assign accept  = req_valid && (q.phase == PH_IDLE);
    assign row_hit = q.open_vld && (q.open_row == req_row);

    always_comb begin
        d           = q;
        d.cmd_valid = 1'b0;
        d.cmd_kind  = CMD_NONE;
        d.rsp_first = 1'b0;
        d.rsp_last  = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;

        unique case (q.phase)
            PH_IDLE: begin
                if (accept) begin
                    d.row      = req_row;
                    d.col_base = {req_col[COL_W-1:IDX_W], {IDX_W{1'b0}}};
                    d.crit     = req_crit[IDX_W-1:0];
                    d.beat     = '0;
                    d.cmd_valid = 1'b1;
                    if (row_hit) begin
                        d.phase    = PH_READ;
                        d.cmd_kind = CMD_READ;
                        d.cmd_row  = req_row;
                        d.cmd_col  = {req_col[COL_W-1:IDX_W], {IDX_W{1'b0}}};
                        tmr_load   = 1'b1;
                        tmr_val    = tcl_eff;
                    end else if (q.open_vld) begin
                        d.phase    = PH_CLOSE;
                        d.cmd_kind = CMD_CLOSE;
                        d.cmd_row  = q.open_row;
                        d.cmd_col  = '0;
                        d.open_vld = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = trp_eff;
                    end else begin
                        d.phase    = PH_OPEN;
                        d.cmd_kind = CMD_OPEN;
                        d.cmd_row  = req_row;
                        d.cmd_col  = '0;
                        d.open_vld = 1'b1;
                        d.open_row = req_row;
                        tmr_load   = 1'b1;
                        tmr_val    = trcd_eff;
                    end
                end
            end
            PH_CLOSE: begin
                if (tmr_expired) begin
                    d.phase     = PH_OPEN;
                    d.cmd_valid = 1'b1;
                    d.cmd_kind  = CMD_OPEN;
                    d.cmd_row   = q.row;
                    d.cmd_col   = '0;
                    d.open_vld  = 1'b1;
                    d.open_row  = q.row;
                    tmr_load    = 1'b1;
                    tmr_val     = trcd_eff;
                end
            end
            PH_OPEN: begin
                if (tmr_expired) begin
                    d.phase     = PH_READ;
                    d.cmd_valid = 1'b1;
                    d.cmd_kind  = CMD_READ;
                    d.cmd_row   = q.row;
                    d.cmd_col   = q.col_base;
                    tmr_load    = 1'b1;
                    tmr_val     = tcl_eff;
                end
            end
            PH_READ: begin
                if (tmr_expired) begin
                    d.phase     = PH_BURST;
                    d.beat      = '0;
                    d.rsp_valid = 1'b1;
                    d.rsp_first = 1'b1;
                    d.rsp_last  = (BURST_CYC == 1);
                end
            end
            PH_BURST: begin
                if (q.rsp_last) begin
                    d.phase     = PH_IDLE;
                    d.rsp_valid = 1'b0;
                end else begin
                    d.beat      = q.beat + BEAT_W'(1);
                    d.rsp_valid = 1'b1;
                    d.rsp_last  = ((q.beat + BEAT_W'(1)) == LAST_BEAT);
                end
            end
            default: begin
                d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // ---------------- burst word order ----------------
    lfs_wrap_order #(.WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W), .BEAT_W(BEAT_W)) i_order (
        .clk   (clk),
        .rst_n (rst_n),
        .active(q.rsp_valid),
        .last  (q.rsp_last),
        .crit  (q.crit),
        .beat  (q.beat),
        .sel   (rd_sel)
    );

    // ---------------- outputs ----------------
    assign req_ready = (q.phase == PH_IDLE);
    assign cmd_valid = q.cmd_valid;
    assign cmd_kind  = q.cmd_kind;
    assign cmd_row   = q.cmd_row;
    assign cmd_col   = q.cmd_col;
    assign rsp_valid = q.rsp_valid;
    assign rsp_first = q.rsp_first;
    assign rsp_last  = q.rsp_last;
    assign rsp_data  = q.rsp_valid ? rd_data : '0;

    logic unused_inputs;
    assign unused_inputs = ^{req_col[IDX_W-1:0], req_crit};

    // ---------------- assertions ----------------
    // R2: after a request is taken the sequencer is busy
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: an open-row hit is served by a read right away
    p_hit_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && q.open_vld && (q.open_row == req_row))
            |=> (cmd_valid && (cmd_kind == CMD_READ)));

    // R4: with nothing open the row is opened without a close
    p_cold_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !q.open_vld) |=> (cmd_valid && (cmd_kind == CMD_OPEN)));

    // R11: commands are single-clock pulses and stay clear of data
    p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    p_no_cmd_in_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_valid);

    // R9: strobes sit inside the burst, which starts on the first strobe
    p_first_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_first |-> rsp_valid);
    p_burst_opens_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> rsp_first);
    p_last_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !rsp_valid);
endmodule

// File: tb/test_lfs_line_sequencer.sv
`timescale 1ns/1ps
module test_lfs_line_sequencer;
    localparam int ROW_W = 14;
    localparam int COL_W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   cfg_trp = 5'd12, cfg_trcd = 5'd12, cfg_tcl = 5'd10;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [13:0]  req_row = '0;
    logic [9:0]   req_col = '0;
    logic [3:0]   req_crit = '0;
    logic         cmd_valid;
    logic [1:0]   cmd_kind;
    logic [13:0]  cmd_row;
    logic [9:0]   cmd_col;
    logic [5:0]   rd_sel;
    logic [127:0] rd_data;
    logic         rsp_valid, rsp_first, rsp_last;
    logic [127:0] rsp_data;

    always #10 clk = ~clk;

    lfs_line_sequencer i_lfs_line_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_tcl(cfg_tcl),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_crit(req_crit),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_first(rsp_first), .rsp_last(rsp_last),
        .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] pat(input logic [13:0] r, input logic [9:0] c,
                                        input logic [2:0] i);
        return {16'hBEEF, 2'b00, r, 6'd0, c, 13'd0, i};
    endfunction

    // bank model: row latch and column set by commands
    logic [13:0] m_row = '0;
    logic [9:0]  m_col = '0;
    always @(posedge clk) begin
        if (cmd_valid && cmd_kind == 2'd2) m_row <= cmd_row;
        if (cmd_valid && cmd_kind == 2'd3) m_col <= cmd_col;
    end
    assign rd_data = {pat(m_row, m_col, rd_sel[5:3]), pat(m_row, m_col, rd_sel[2:0])};

    typedef struct {
        int          at;
        logic [1:0]  kind;
        logic [13:0] row;
        logic [9:0]  col;
        string       tag;
    } cmd_exp_t;

    typedef struct {
        int           at;
        logic [2:0]   i0, i1;
        logic         first, last;
        logic [127:0] data;
        string        tag;
    } beat_exp_t;

    cmd_exp_t  cmd_q[$];
    beat_exp_t beat_q[$];

    bit          mdl_open = 0;
    logic [13:0] mdl_row = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int clampd(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // driver: waits for idle, predicts commands and beats, then issues
    task automatic send(input int row, input int col, input int crit, input string tag);
        int a, tp, tr, tc, lat, c;
        logic [9:0] base;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tp   = clampd(int'(cfg_trp), 12, 15);
        tr   = clampd(int'(cfg_trcd), 12, 15);
        tc   = clampd(int'(cfg_tcl), 10, 12);
        base = 10'(col) & 10'h3F8;
        c    = crit % 8;
        a    = cyc + 1;
        if (mdl_open && mdl_row == 14'(row)) begin
            cmd_q.push_back('{a, 2'd3, 14'(row), base, tag});
            lat = tc;
        end else if (mdl_open) begin
            cmd_q.push_back('{a, 2'd1, mdl_row, 10'd0, tag});
            cmd_q.push_back('{a + tp, 2'd2, 14'(row), 10'd0, tag});
            cmd_q.push_back('{a + tp + tr, 2'd3, 14'(row), base, tag});
            lat = tp + tr + tc;
        end else begin
            cmd_q.push_back('{a, 2'd2, 14'(row), 10'd0, tag});
            cmd_q.push_back('{a + tr, 2'd3, 14'(row), base, tag});
            lat = tr + tc;
        end
        mdl_open = 1;
        mdl_row  = 14'(row);
        for (int k = 0; k < 4; k++) begin
            beat_exp_t b;
            b.at    = a + lat + k;
            b.i0    = 3'((c + 2 * k) % 8);
            b.i1    = 3'((c + 2 * k + 1) % 8);
            b.first = (k == 0);
            b.last  = (k == 3);
            b.data  = {pat(14'(row), base, b.i1), pat(14'(row), base, b.i0)};
            b.tag   = tag;
            beat_q.push_back(b);
        end
        req_valid = 1'b1;
        req_row   = 14'(row);
        req_col   = 10'(col);
        req_crit  = 4'(crit);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (cmd_q.size() != 0 || beat_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    // monitor: compares every command and beat against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (cmd_q.size() == 0) begin
                    chk(0, "R11", "unexpected command", {126'd0, cmd_kind}, 128'd0);
                end else begin
                    cmd_exp_t e;
                    e = cmd_q.pop_front();
                    chk(cyc == e.at, e.tag, "command clock", 128'(cyc), 128'(e.at));
                    chk(cmd_kind == e.kind && cmd_row == e.row, e.tag, "command kind/row",
                        {112'd0, cmd_kind, cmd_row}, {112'd0, e.kind, e.row});
                    chk(cmd_col == e.col, "R10", "command column", 128'(cmd_col), 128'(e.col));
                end
            end
            if (rsp_valid) begin
                if (beat_q.size() == 0) begin
                    chk(0, "R7", "unexpected beat", 128'd1, 128'd0);
                end else begin
                    beat_exp_t e;
                    e = beat_q.pop_front();
                    chk(cyc == e.at, e.first ? e.tag : "R7", "beat clock", 128'(cyc), 128'(e.at));
                    chk(rd_sel == {e.i1, e.i0}, "R8", "word order", 128'(rd_sel),
                        128'({e.i1, e.i0}));
                    chk(rsp_first == e.first && rsp_last == e.last, "R9", "first/last",
                        128'({rsp_first, rsp_last}), 128'({e.first, e.last}));
                    chk(rsp_data == e.data, "R9", "burst data", rsp_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(req_ready == 1'b1 && cmd_valid == 1'b0 && rsp_valid == 1'b0, "R1", "reset state",
            128'({req_ready, cmd_valid, rsp_valid}), 128'(3'b100));

        // R4: first access after reset opens without closing
        send(5, 10'h013, 3, "R4");
        drain();
        // R5: same row, critical word near the end wraps
        send(5, 10'h020, 6, "R5");
        drain();
        // R3: different row with longer delays
        cfg_trp = 5'd15; cfg_trcd = 5'd14; cfg_tcl = 5'd12;
        send(9, 10'h1FF, 0, "R3");
        drain();
        // R6: delays below their windows
        cfg_trp = 5'd3; cfg_trcd = 5'd0; cfg_tcl = 5'd1;
        send(300, 10'h088, 7, "R6");
        drain();
        // R6: delays above their windows
        cfg_trp = 5'd31; cfg_trcd = 5'd20; cfg_tcl = 5'd30;
        send(301, 10'h047, 2, "R6");
        drain();
        // R8: critical index 9 wraps modulo 8 to word 1, on a row hit
        cfg_trp = 5'd13; cfg_trcd = 5'd12; cfg_tcl = 5'd11;
        send(301, 10'h3C5, 9, "R5");
        drain();

        // R2: a request made while busy is ignored
        send(1000, 10'h010, 4, "R3");
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_row = 14'd77; req_col = 10'h2A0; req_crit = 4'd5;
        for (int k = 0; k < 3; k++) begin
            chk(req_ready == 1'b0, "R2", "ready while busy", 128'(req_ready), 128'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        drain();
        // R2: row 1000 still open, so this is a hit
        send(1000, 10'h011, 1, "R2");
        drain();

        // back-to-back misses alternating rows
        send(2, 10'h000, 5, "R3");
        send(3, 10'h008, 3, "R3");
        drain();

        chk(cmd_q.size() == 0 && beat_q.size() == 0, "R7", "scoreboard empty",
            128'(cmd_q.size() + beat_q.size()), 128'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule